// File: doc/BRIEF.md
# ADC Threshold Compare Unit

This unit watches the stream of finished 12-bit conversion results from an analog front end and classifies each one against a pair of limits, low and high. There are two such pairs. Each channel has its own select bit that picks which pair it uses. For each of twelve channels the unit keeps two pieces of status. The first is a 2-bit range code that says where the latest result lies. The second is a 2-bit crossing code that says whether the low limit was crossed since the previous result on that channel, and in which direction.

A small write-only configuration port sets the four limits, the per-channel pair selects and the per-channel interrupt enables. A write to a clear address resets the status of the channels named in the write. Each channel has a 2-bit interrupt enable. It chooses whether out-of-range results, low-limit crossings, or nothing set that channel's pending flag. The single interrupt request output is the OR of all pending flags. Results arrive as a one-cycle strobe with a channel number and a value. Status updates on the same clock edge as the strobe.

Top module: `thrcmp_top`

## Requirements
- R1: A conversion on channel i is compared with pair 0 when bit i of the select register is 0, and with pair 1 when that bit is 1. Limits and selects in force before a clock edge are used for a conversion at that edge.
- R2: The range code is 01 when the result is strictly below the selected low limit. It is 10 when the result is strictly above the selected high limit and not below the low limit. Otherwise it is 00.
- R3: A result equal to the low limit, or equal to the high limit, gives range code 00.
- R4: The crossing code is 11 when the previous result on the channel was below the low limit and the new one is at or above it. It is 10 when the previous result was at or above the low limit and the new one is below it. It is 00 when neither applies.
- R5: The first conversion on a channel after reset reports crossing code 00.
- R6: The 2-bit enable for channel i sits at write-data bits [2i+1:2i]. With 01, a conversion with range code other than 00 sets that channel's pending flag. With 10, a conversion with crossing code 11 or 10 sets it. With 00 or 11, nothing sets it. The interrupt output is high when any pending flag is set.
- R7: The status of a channel changes only on a conversion strobe for that channel or a clear naming it. Strobes with a channel number of 12 or more change nothing.
- R8: A write to the clear address sets the range code, the crossing code and the pending flag to zero for every channel whose bit is 1 in write-data bits [11:0]. A conversion on the same channel at the same edge takes priority: the statuses take the conversion's values, and the pending flag is set if that conversion raises an event.
- R9: After reset, the low limits are 0, the high limits are 0xFFF, the selects and enables are 0, all status is 0 and the interrupt output is low.
- R10: Write addresses: 0 is low limit of pair 0, 1 is high limit of pair 0, 2 is low limit of pair 1, 3 is high limit of pair 1 (all in data bits [11:0]). 4 is the select register (bits [11:0]), 5 is the enable register (bits [23:0]) and 6 is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe for a finished conversion |
| conv_chan | input | 4 | Channel number of the conversion |
| conv_result | input | 12 | Conversion result |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration write address |
| cfg_wdata | input | 24 | Configuration write data |
| range_stat | output | 24 | Range code per channel, channel i at [2i+1:2i] |
| cross_stat | output | 24 | Crossing code per channel, channel i at [2i+1:2i] |
| irq_pend | output | 12 | Pending interrupt flag per channel |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
The bench drives results that sit exactly on each limit and one step either side of it. A design with an off-by-one comparison would report 01 or 10 where 00 is required. It follows long runs of results on one channel that jump back and forth across the low limit. A design that swapped the direction bit, or forgot the previous sample, would show a wrong crossing code on the step where the crossing happens or on the first conversion. Conversions that land in the same cycle as a clear, or as a limit or enable write, catch a design that gives the wrong priority or uses the new value one edge too early. Enable value 11 and channel numbers above the last channel must leave the interrupt and the status untouched.

// File: rtl/thrcmp_pkg.sv
package thrcmp_pkg;
    localparam logic [2:0] ADDR_LO0 = 3'd0;
    localparam logic [2:0] ADDR_HI0 = 3'd1;
    localparam logic [2:0] ADDR_LO1 = 3'd2;
    localparam logic [2:0] ADDR_HI1 = 3'd3;
    localparam logic [2:0] ADDR_SEL = 3'd4;
    localparam logic [2:0] ADDR_EN  = 3'd5;
    localparam logic [2:0] ADDR_CLR = 3'd6;

    localparam logic [1:0] RNG_IN    = 2'b00;
    localparam logic [1:0] RNG_BELOW = 2'b01;
    localparam logic [1:0] RNG_ABOVE = 2'b10;

    localparam logic [1:0] XING_NONE = 2'b00;
    localparam logic [1:0] XING_FALL = 2'b10;
    localparam logic [1:0] XING_RISE = 2'b11;

    localparam logic [1:0] IEN_RANGE = 2'b01;
    localparam logic [1:0] IEN_XING  = 2'b10;

    typedef struct packed {
        logic [1:0] rng;
        logic [1:0] xing;
        logic       below;
        logic       seen;
        logic       pend;
    } chan_state_t;
endpackage

// File: rtl/thrcmp_regs.sv
module thrcmp_regs
    import thrcmp_pkg::*;
#(
    parameter int NCH = 12,
    parameter int RW  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [2:0]             cfg_addr,
    input  logic [2*NCH-1:0]       cfg_wdata,
    output logic [1:0][RW-1:0]     lo,
    output logic [1:0][RW-1:0]     hi,
    output logic [NCH-1:0]         sel,
    output logic [2*NCH-1:0]       en,
    output logic [NCH-1:0]         clr_mask
);
    typedef struct packed {
        logic [1:0][RW-1:0] lo;
        logic [1:0][RW-1:0] hi;
        logic [NCH-1:0]     sel;
        logic [2*NCH-1:0]   en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_LO0: cfg_d.lo[0] = cfg_wdata[RW-1:0];
                ADDR_HI0: cfg_d.hi[0] = cfg_wdata[RW-1:0];
                ADDR_LO1: cfg_d.lo[1] = cfg_wdata[RW-1:0];
                ADDR_HI1: cfg_d.hi[1] = cfg_wdata[RW-1:0];
                ADDR_SEL: cfg_d.sel   = cfg_wdata[NCH-1:0];
                ADDR_EN:  cfg_d.en    = cfg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.lo  <= '0;
            cfg_q.hi  <= '1;
            cfg_q.sel <= '0;
            cfg_q.en  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lo       = cfg_q.lo;
    assign hi       = cfg_q.hi;
    assign sel      = cfg_q.sel;
    assign en       = cfg_q.en;
    assign clr_mask = (cfg_we && cfg_addr == ADDR_CLR) ? cfg_wdata[NCH-1:0] : '0;

    // R10: a select write lands in the select register one edge later
    assert_sel_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_SEL) |=> (sel == $past(cfg_wdata[NCH-1:0])));
endmodule

// File: rtl/thrcmp_classify.sv
module thrcmp_classify
    import thrcmp_pkg::*;
#(
    parameter int RW = 12
) (
    input  logic [RW-1:0] result,
    input  logic [RW-1:0] lo,
    input  logic [RW-1:0] hi,
    output logic [1:0]    rng,
    output logic          below
);
    logic above;

    always_comb begin
        below = (result < lo);
        above = (result > hi);
        if (below)      rng = RNG_BELOW;
        else if (above) rng = RNG_ABOVE;
        else            rng = RNG_IN;
    end
endmodule

// File: rtl/thrcmp_chan.sv
module thrcmp_chan
    import thrcmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       clr,
    input  logic [1:0] rng_in,
    input  logic       below_in,
    input  logic [1:0] en,
    output logic [1:0] rng,
    output logic [1:0] xing,
    output logic       pend
);
    chan_state_t st_d, st_q;
    logic [1:0]  xing_new;
    logic        event_hit;

    always_comb begin
        st_d     = st_q;
        xing_new = XING_NONE;
        if (st_q.seen && (st_q.below != below_in))
            xing_new = st_q.below ? XING_RISE : XING_FALL;
        event_hit = hit && (((en == IEN_RANGE) && (rng_in != RNG_IN)) ||
                            ((en == IEN_XING)  && xing_new[1]));
        if (clr) begin
            st_d.rng  = RNG_IN;
            st_d.xing = XING_NONE;
            st_d.pend = 1'b0;
        end
        if (hit) begin
            st_d.rng   = rng_in;
            st_d.xing  = xing_new;
            st_d.below = below_in;
            st_d.seen  = 1'b1;
        end
        if (event_hit)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rng  = st_q.rng;
    assign xing = st_q.xing;
    assign pend = st_q.pend;

    assert_range_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rng != 2'b11);
    assert_cross_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.xing != 2'b01);
    assert_first_nocross_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !st_q.seen) |=> (st_q.xing == XING_NONE));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !clr) |=> ($stable(st_q.rng) && $stable(st_q.xing)));
    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((en == 2'b00 || en == 2'b11) && !st_q.pend) |=> !st_q.pend);
endmodule

// File: rtl/thrcmp_top.sv
module thrcmp_top
    import thrcmp_pkg::*;
#(
    parameter int NCH = 12,
    parameter int RW  = 12,
    parameter int CHW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               conv_valid,
    input  logic [CHW-1:0]     conv_chan,
    input  logic [RW-1:0]      conv_result,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [2*NCH-1:0]   cfg_wdata,
    output logic [2*NCH-1:0]   range_stat,
    output logic [2*NCH-1:0]   cross_stat,
    output logic [NCH-1:0]     irq_pend,
    output logic               cmp_irq
);
    logic [1:0][RW-1:0] lo, hi;
    logic [NCH-1:0]     sel;
    logic [2*NCH-1:0]   en;
    logic [NCH-1:0]     clr_mask;
    logic               pair;
    logic [1:0]         rng_new;
    logic               below_new;

    thrcmp_regs #(.NCH(NCH), .RW(RW)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lo(lo), .hi(hi), .sel(sel), .en(en),
        .clr_mask(clr_mask)
    );

    always_comb begin
        pair = 1'b0;
        for (int k = 0; k < NCH; k++)
            if (conv_chan == CHW'(k)) pair = sel[k];
    end

    thrcmp_classify #(.RW(RW)) i_classify (
        .result(conv_result), .lo(lo[pair]), .hi(hi[pair]),
        .rng(rng_new), .below(below_new)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic hit;
        assign hit = conv_valid && (conv_chan == CHW'(i));
        thrcmp_chan i_chan (
            .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr_mask[i]),
            .rng_in(rng_new), .below_in(below_new), .en(en[2*i+1:2*i]),
            .rng(range_stat[2*i+1:2*i]), .xing(cross_stat[2*i+1:2*i]),
            .pend(irq_pend[i])
        );
    end

    assign cmp_irq = |irq_pend;

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_irq) |-> $past(conv_valid));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_CLR && cfg_wdata[NCH-1:0] == '1 && !conv_valid) |=> !cmp_irq);
endmodule

// File: tb/test_thrcmp_top.sv
`timescale 1ns/1ps
module test_thrcmp_top;
    localparam int NCH = 12;
    localparam int RW  = 12;

    logic clk = 0, rst_n = 0;
    logic conv_valid = 0;
    logic [3:0] conv_chan = 0;
    logic [11:0] conv_result = 0;
    logic cfg_we = 0;
    logic [2:0] cfg_addr = 0;
    logic [23:0] cfg_wdata = 0;
    logic [23:0] range_stat, cross_stat;
    logic [11:0] irq_pend;
    logic cmp_irq;

    int checks = 0, failures = 0;

    // bench model
    logic [11:0] m_lo [2];
    logic [11:0] m_hi [2];
    logic [11:0] m_sel;
    logic [23:0] m_en;
    logic [1:0]  m_rng [NCH];
    logic [1:0]  m_x   [NCH];
    logic        m_bel [NCH];
    logic        m_seen[NCH];
    logic        m_pend[NCH];

    always #2 clk = ~clk;

    thrcmp_top i_thrcmp_top (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_chan(conv_chan),
        .conv_result(conv_result), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .range_stat(range_stat), .cross_stat(cross_stat),
        .irq_pend(irq_pend), .cmp_irq(cmp_irq)
    );

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic logic [1:0] exp_range(input logic [11:0] r, input logic [11:0] lo,
                                             input logic [11:0] hi);
        if (r < lo) return 2'b01;
        if (r > hi) return 2'b10;
        return 2'b00;
    endfunction

    task automatic model_reset();
        m_lo[0] = 0; m_lo[1] = 0; m_hi[0] = 12'hFFF; m_hi[1] = 12'hFFF;
        m_sel = 0; m_en = 0;
        for (int i = 0; i < NCH; i++) begin
            m_rng[i] = 0; m_x[i] = 0; m_bel[i] = 0; m_seen[i] = 0; m_pend[i] = 0;
        end
    endtask

    // apply one edge of the model using old configuration
    task automatic model_edge(input logic cv, input logic [3:0] ch, input logic [11:0] r,
                              input logic we, input logic [2:0] ad, input logic [23:0] wd);
        logic p, b, ev;
        logic [1:0] rg, xg, e;
        if (we && ad == 3'd6)
            for (int i = 0; i < NCH; i++)
                if (wd[i]) begin m_rng[i] = 0; m_x[i] = 0; m_pend[i] = 0; end
        if (cv && ch < NCH) begin
            p  = m_sel[ch];
            rg = exp_range(r, m_lo[p], m_hi[p]);
            b  = (r < m_lo[p]);
            xg = 2'b00;
            if (m_seen[ch] && m_bel[ch] != b) xg = m_bel[ch] ? 2'b11 : 2'b10;
            e  = m_en[2*ch +: 2];
            ev = (e == 2'b01 && rg != 0) || (e == 2'b10 && xg != 0);
            m_rng[ch] = rg; m_x[ch] = xg; m_bel[ch] = b; m_seen[ch] = 1;
            if (ev) m_pend[ch] = 1;
        end
        if (we)
            case (ad)
                3'd0: m_lo[0] = wd[11:0];
                3'd1: m_hi[0] = wd[11:0];
                3'd2: m_lo[1] = wd[11:0];
                3'd3: m_hi[1] = wd[11:0];
                3'd4: m_sel   = wd[11:0];
                3'd5: m_en    = wd;
                default: ;
            endcase
    endtask

    task automatic check_all(input string tag);
        logic any;
        any = 0;
        for (int i = 0; i < NCH; i++) begin
            checks++;
            if (range_stat[2*i +: 2] !== m_rng[i] || cross_stat[2*i +: 2] !== m_x[i] ||
                irq_pend[i] !== m_pend[i]) begin
                failures++;
                $display("FAIL %s ch%0d: actual rng=%b x=%b p=%b expected rng=%b x=%b p=%b",
                         tag, i, range_stat[2*i +: 2], cross_stat[2*i +: 2], irq_pend[i],
                         m_rng[i], m_x[i], m_pend[i]);
            end
            any |= m_pend[i];
        end
        checks++;
        if (cmp_irq !== any) begin
            failures++;
            $display("FAIL %s irq: actual %b expected %b", tag, cmp_irq, any);
        end
    endtask

    // drive at negedge, edge happens, compare at next negedge
    task automatic step(input logic cv, input logic [3:0] ch, input logic [11:0] r,
                        input logic we, input logic [2:0] ad, input logic [23:0] wd,
                        input string tag);
        conv_valid = cv; conv_chan = ch; conv_result = r;
        cfg_we = we; cfg_addr = ad; cfg_wdata = wd;
        @(posedge clk);
        model_edge(cv, ch, r, we, ad, wd);
        @(negedge clk);
        conv_valid = 0; cfg_we = 0;
        check_all(tag);
    endtask

    task automatic conv(input logic [3:0] ch, input logic [11:0] r, input string tag);
        step(1, ch, r, 0, 0, 0, tag);
    endtask

    task automatic wr(input logic [2:0] ad, input logic [23:0] wd, input string tag);
        step(0, 0, 0, 1, ad, wd, tag);
    endtask

    initial begin
        int s;
        s = $urandom(32'h5EED1);
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R9");
        rst_n = 1;
        @(negedge clk);
        check_all("R9");

        wr(0, 100, "R10"); wr(1, 200, "R10");
        wr(2, 1000, "R10"); wr(3, 2000, "R10");
        wr(4, 12'h008, "R1");
        conv(0, 50, "R5");          // first: below, no crossing
        conv(0, 100, "R3");         // equal low -> in range, rising crossing
        conv(0, 200, "R3");         // equal high -> in range
        conv(0, 201, "R2");         // above high
        conv(0, 99, "R4");          // falling crossing
        conv(0, 98, "R4");          // stays below, no crossing
        conv(3, 500, "R1");         // pair 1: below 1000
        conv(3, 2001, "R1");        // pair 1: above
        conv(4, 500, "R7");         // other channel only
        conv(12, 0, "R7");          // out-of-range channel number
        conv(15, 0, "R7");

        wr(5, 24'h000001, "R6");    // ch0 range enable
        conv(0, 150, "R6");         // in range -> no pend
        conv(0, 250, "R6");         // above -> pend
        wr(6, 24'h001, "R8");       // clear ch0
        wr(5, 24'h000002, "R6");    // ch0 crossing enable
        conv(0, 250, "R6");
        conv(0, 10, "R6");          // falling crossing -> pend
        wr(6, 24'h001, "R8");
        wr(5, 24'h000003, "R6");    // 11 disabled
        conv(0, 4000, "R6");
        conv(0, 0, "R6");
        wr(5, 24'h000001, "R8");
        step(1, 0, 4095, 1, 6, 24'h001, "R8");  // conversion beats clear
        step(1, 0, 150, 1, 0, 200, "R1");       // limit write same edge uses old limit

        for (int n = 0; n < 4000; n++) begin
            logic cv, we;
            logic [3:0] ch;
            logic [11:0] r;
            logic [2:0] ad;
            logic [23:0] wd;
            cv = ($urandom % 4) != 0;
            ch = 4'($urandom % 14);
            r  = 12'($urandom);
            if ($urandom % 3 == 0) r = m_lo[m_sel[ch % NCH]] + 12'($urandom % 3) - 12'd1;
            we = ($urandom % 6) == 0;
            ad = 3'($urandom % 7);
            wd = 24'($urandom);
            step(cv, ch, r, we, ad, wd, "R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule